// File: doc/BRIEF.md
# Pulse Width Capture Unit

This block watches one asynchronous input line, typically the demodulated output of an infrared receiver, and measures how many clock cycles each high level and each low level lasts. When the line changes level, the length of the interval that just ended goes into one of two period registers: one for high intervals, one for low intervals. A status bit records which of the two was just written, and an interrupt is raised.

Software configures the unit through a small register interface. Reads are combinational and writes are single-cycle. It sets a run bit and a capture-mode bit, and it can enable the interrupt. In its handler it reads the status word and uses the level bit to pick the period register that holds the new value. It then clears the pending flag by writing a one to it. A sticky overrun bit shows that an interval was captured while the previous one was still unacknowledged. Counters saturate instead of wrapping, so a very long idle level reads as the maximum count.

Register map (word addresses on `busAddr`): 0 = control (bit0 run, bit1 capture mode), 1 = interrupt enable (bit0), 2 = status (bit0 pending, bit1 overrun, bit2 level), 3 = high period, 4 = low period. Any other address reads as zero.

Top module: `pwc_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The unit counts and captures only while both control bit0 (run) and control bit1 (capture mode) are set. With either bit clear, level changes on `sigIn` leave both period registers and the status word unchanged.
- R3: The first level change after the unit becomes active only starts timing. It loads no period register and does not set pending. Clearing run or mode returns the unit to this unarmed state.
- R4: On a falling level change, the high period register (address 3) takes the number of clock cycles the input was high. On a rising level change, the low period register (address 4) takes the number of cycles it was low.
- R5: Status bit2 is 1 when the interval just captured was high, and 0 when it was low. It keeps its value until the next capture.
- R6: Status bit0 (pending) is set on every capture and cleared by writing 1 to bit0 of the status word. Writing 0 has no effect. If a capture and a clear fall in the same cycle, the set wins.
- R7: `irq` is high exactly when pending is set and interrupt-enable bit0 is set.
- R8: Status bit1 (overrun) is set when a capture occurs while pending is already set. It stays set until software writes 1 to bit1, and such a write leaves the other status bits unchanged.
- R9: A count that reaches 2^CNT_W-1 holds there, and that value is what is captured.
- R10: `sigIn` passes through a two-stage synchroniser. A level change driven just after clock edge 0 becomes visible in the registers after clock edge 3, and not after edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sigIn | input | 1 | Asynchronous line to be measured |
| busAddr | input | 3 | Register word address |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data for `busAddr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench first toggles the line with the unit idle, then with only the run bit set. This separates real gating of both control bits from gating on run alone. With the unit active it drives a high of 10 cycles, a low of 7 and a high of 5. Different lengths expose swapped period registers and off-by-one counting, and the alternating levels check the level bit. The second capture is left unacknowledged to provoke overrun. A high held for 300 cycles against an 8-bit counter shows saturation instead of wrap. The unit is then disabled and re-enabled to show that the next level change only re-arms it.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int ADDR_W = 3;
  typedef logic [ADDR_W-1:0] regAddr_t;

  localparam regAddr_t A_CTRL   = 3'd0;
  localparam regAddr_t A_IRQEN  = 3'd1;
  localparam regAddr_t A_STATUS = 3'd2;
  localparam regAddr_t A_HIGH   = 3'd3;
  localparam regAddr_t A_LOW    = 3'd4;

  // strobes from the control side into the counting datapath
  typedef struct packed {
    logic clear;      // unit inactive: hold count at zero
    logic restart;    // level change seen: count from one
    logic latchHigh;  // store count as high period
    logic latchLow;   // store count as low period
  } pwcStrobes_t;
endpackage

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
  import pwc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sigIn,
  input  logic        wrEn,
  input  regAddr_t    wrAddr,
  input  logic [1:0]  wrBits,
  output pwcStrobes_t stb,
  output logic        runBit,
  output logic        modeBit,
  output logic        irqEnBit,
  output logic        pendQ,
  output logic        ovfQ,
  output logic        polQ,
  output logic        irq
);
  logic syncA, syncB, lvlPrev, armed;
  logic active, edgeSeen, capture;
  logic wrStatus;

  assign active   = runBit & modeBit;
  assign edgeSeen = active & (syncB != lvlPrev);
  assign capture  = edgeSeen & armed;
  assign wrStatus = wrEn && (wrAddr == A_STATUS);

  always_comb begin
    stb.clear     = ~active;
    stb.restart   = edgeSeen;
    stb.latchHigh = capture & lvlPrev;
    stb.latchLow  = capture & ~lvlPrev;
  end

  // two-stage synchroniser and previous level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      lvlPrev <= 1'b0;
    end else begin
      syncA   <= sigIn;
      syncB   <= syncA;
      lvlPrev <= syncB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          armed <= 1'b0;
    else if (!active)   armed <= 1'b0;
    else if (edgeSeen)  armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit   <= 1'b0;
      modeBit  <= 1'b0;
      irqEnBit <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == A_CTRL) begin
        runBit  <= wrBits[0];
        modeBit <= wrBits[1];
      end
      if (wrAddr == A_IRQEN) irqEnBit <= wrBits[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      ovfQ  <= 1'b0;
      polQ  <= 1'b0;
    end else begin
      if (capture)                      pendQ <= 1'b1;
      else if (wrStatus && wrBits[0])   pendQ <= 1'b0;
      if (capture && pendQ)             ovfQ  <= 1'b1;
      else if (wrStatus && wrBits[1])   ovfQ  <= 1'b0;
      if (capture)                      polQ  <= lvlPrev;
    end
  end

  assign irq = pendQ & irqEnBit;
endmodule

// File: rtl/pwc_datapath.sv
module pwc_datapath
  import pwc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwcStrobes_t      stb,
  output logic [CNT_W-1:0] highQ,
  output logic [CNT_W-1:0] lowQ
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (stb.clear)      cnt <= '0;
    else if (stb.restart)    cnt <= CNT_ONE;
    else if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highQ <= '0;
      lowQ  <= '0;
    end else begin
      if (stb.latchHigh) highQ <= cnt;
      if (stb.latchLow)  lowQ  <= cnt;
    end
  end
endmodule

// File: rtl/pwc_top.sv
module pwc_top
  import pwc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sigIn,
  input  logic [2:0]        busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);
  pwcStrobes_t      stb;
  logic             runBit, modeBit, irqEnBit;
  logic             pendQ, ovfQ, polQ;
  logic [CNT_W-1:0] highQ, lowQ;
  logic             unusedWrBits;

  assign unusedWrBits = ^busWrData[DATA_W-1:2];

  pwc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sigIn(sigIn),
    .wrEn(busWrEn), .wrAddr(busAddr), .wrBits(busWrData[1:0]),
    .stb(stb), .runBit(runBit), .modeBit(modeBit), .irqEnBit(irqEnBit),
    .pendQ(pendQ), .ovfQ(ovfQ), .polQ(polQ), .irq(irq)
  );

  pwc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .highQ(highQ), .lowQ(lowQ)
  );

  always_comb begin
    busRdData = '0;
    case (busAddr)
      A_CTRL:   busRdData = DATA_W'({modeBit, runBit});
      A_IRQEN:  busRdData = DATA_W'(irqEnBit);
      A_STATUS: busRdData = DATA_W'({polQ, ovfQ, pendQ});
      A_HIGH:   busRdData = DATA_W'(highQ);
      A_LOW:    busRdData = DATA_W'(lowQ);
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker
  import pwc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             irq,
  input logic             busWrEn,
  input logic [2:0]       busAddr,
  input logic [1:0]       wrLow,
  input pwcStrobes_t      stb,
  input logic             runBit,
  input logic             modeBit,
  input logic             irqEnBit,
  input logic             pendQ,
  input logic             ovfQ,
  input logic [CNT_W-1:0] highQ,
  input logic [CNT_W-1:0] lowQ
);
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqEnBit && pendQ));

  a_r6_capture_sets_pending: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latchHigh || stb.latchLow) |=> pendQ);

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !(busWrEn && busAddr == A_STATUS && wrLow[1])) |=> ovfQ);

  a_r4_one_register_per_edge: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.latchHigh, stb.latchLow}));

  a_r2_idle_no_capture: assert property (@(posedge clk) disable iff (!rstN)
    !(runBit && modeBit) |=> ($stable(highQ) && $stable(lowQ)));

  a_r4_high_holds: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchHigh |=> $stable(highQ));
endmodule

bind pwc_top pwc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .irq(irq), .busWrEn(busWrEn), .busAddr(busAddr),
  .wrLow(busWrData[1:0]), .stb(stb), .runBit(runBit), .modeBit(modeBit),
  .irqEnBit(irqEnBit), .pendQ(pendQ), .ovfQ(ovfQ), .highQ(highQ), .lowQ(lowQ)
);

// File: tb/tb_pwc_top.sv
module tb_pwc_top;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sigIn = 1'b0;
  logic [2:0]        busAddr = 3'd0;
  logic              busWrEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwc_top #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [DATA_W-1:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [DATA_W-1:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic expectReg(input string req, input string what,
                           input logic [2:0] a, input logic [DATA_W-1:0] exp);
    logic [DATA_W-1:0] v;
    busRead(a, v);
    check(req, what, v, exp);
  endtask

  task automatic testReset();
    expectReg("R1", "ctrl", 3'd0, 0);
    expectReg("R1", "irqen", 3'd1, 0);
    expectReg("R1", "status", 3'd2, 0);
    expectReg("R1", "high", 3'd3, 0);
    expectReg("R1", "low", 3'd4, 0);
    check("R1", "irq", DATA_W'(irq), 0);
  endtask

  task automatic testGating();
    for (int mode = 0; mode < 3; mode++) begin
      busWrite(3'd0, DATA_W'(mode));
      for (int k = 0; k < 3; k++) begin
        sigIn = 1'b1; waitCyc(6);
        sigIn = 1'b0; waitCyc(6);
      end
      waitCyc(4);
      expectReg("R2", "high idle", 3'd3, 0);
      expectReg("R2", "low idle", 3'd4, 0);
      expectReg("R2", "status idle", 3'd2, 0);
    end
  endtask

  task automatic testCapture();
    busWrite(3'd0, 3);
    waitCyc(3);
    sigIn = 1'b1;                 // arming edge
    waitCyc(4);
    expectReg("R3", "no capture on first edge", 3'd2, 0);
    waitCyc(6);                   // high held 10 cycles
    sigIn = 1'b0;
    waitCyc(4);
    expectReg("R4", "high 10", 3'd3, 10);
    expectReg("R5", "status after high", 3'd2, 5);
    check("R7", "irq disabled", DATA_W'(irq), 0);
    busWrite(3'd1, 1);            // low cycle 5
    check("R7", "irq enabled", DATA_W'(irq), 1);
    busWrite(3'd2, 1);            // low cycle 6
    expectReg("R6", "pending cleared", 3'd2, 4);
    check("R7", "irq after clear", DATA_W'(irq), 0);
    waitCyc(1);                   // low held 7 cycles
    sigIn = 1'b1;
    waitCyc(2);
    expectReg("R10", "not yet after two edges", 3'd2, 4);
    waitCyc(1);
    expectReg("R10", "visible after three edges", 3'd2, 1);
    expectReg("R4", "low 7", 3'd4, 7);
    check("R7", "irq raised", DATA_W'(irq), 1);
    waitCyc(2);                   // high held 5 cycles
    sigIn = 1'b0;
    waitCyc(4);
    expectReg("R4", "high 5", 3'd3, 5);
    expectReg("R8", "overrun set", 3'd2, 7);
    busWrite(3'd2, 0);
    expectReg("R6", "write zero ignored", 3'd2, 7);
    busWrite(3'd2, 2);
    expectReg("R8", "overrun cleared alone", 3'd2, 5);
    busWrite(3'd2, 1);
    expectReg("R5", "level kept", 3'd2, 4);
  endtask

  task automatic testSaturate();
    sigIn = 1'b1; waitCyc(300);
    sigIn = 1'b0; waitCyc(4);
    expectReg("R9", "high saturated", 3'd3, 255);
    busWrite(3'd2, 3);
    busWrite(3'd0, 0);
    busWrite(3'd0, 3);
    waitCyc(3);
    sigIn = 1'b1; waitCyc(5);
    expectReg("R3", "re-armed only", 3'd2, 4);
    sigIn = 1'b0; waitCyc(4);
    expectReg("R3", "capture after re-arm", 3'd3, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGating();
    testCapture();
    testSaturate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule